// File: doc/BRIEF.md
# Comma-Aligned Receive Word Framer

The framer sits behind a clock and data recovery stage. It accepts the recovered serial stream one bit per clock, qualified by a bit strobe, and packs the bits into 10-bit characters. Each character comes out with a one-cycle word strobe. A flag marks the characters that are positive-polarity 8B/10B commas.

With framing switched on, the framer checks every bit position for the comma and moves the character boundary onto it. The comma is then the first character at the new boundary, and any partly collected character before it is dropped. With framing switched off, the framer only cuts the stream every ten bits at the boundary it already holds. The framing enable passes through a short synchronizer, so a change of the enable takes effect within two clocks. That is well inside the three-character limit on the comma flag's response.

Top module: `comma_word_framer`

## Requirements
- R1: After reset, `word_vld` and `comma_flag` are low. No word strobe is issued until ten strobed bits have been received.
- R2: In `word_out`, bit 0 holds the earliest received bit of the character and bit 9 holds the latest.
- R3: `word_vld` pulses for one clock, on the clock that accepts the tenth strobed bit since the last character (or since reset). A clock with `bit_vld` low never produces a strobe and does not advance the bit count.
- R4: With framing active, a comma is any character whose bits 0..6 are 0,0,1,1,1,1,1, so `word_out[6:0] == 7'b1111100`. When the tenth bit of that character arrives, the character is output at once with `comma_flag` high.
- R5: The opposite-polarity pattern 1,1,0,0,0,0,0 (`word_out[6:0] == 7'b0000011`) never raises `comma_flag` and never moves the boundary.
- R6: After a flagged comma, the next character is output exactly ten strobed bits later. Bits collected before the comma that did not make a full character are never output on their own.
- R7: With framing inactive, `comma_flag` stays low and characters are cut strictly every ten bits, even when a comma passes at another offset.
- R8: A change of `frame_en` governs every bit accepted from the second clock after the change onward. This is within three character times.
- R9: Detection uses a sliding window checked on every bit, so a comma that straddles the current boundary is found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_en | input | 1 | High: align on commas. Low: free-running, unframed output |
| bit_vld | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Recovered serial bit |
| word_vld | output | 1 | One-clock strobe for `word_out` |
| word_out | output | 10 | Parallel character, bit 0 received first |
| comma_flag | output | 1 | High with `word_vld` when the character is an aligned comma |

## Verification
The hardest case to reach is a comma that straddles an established boundary right after framing is switched on. Hitting it needs a known boundary phase, a settled synchronizer and a chosen bit offset all at once. The stimulus first sends whole characters in unframed mode, so the boundary phase is known. It then idles long enough for the enable to pass through the synchronizer, and sends four filler bits before the comma. Random stretches with gaps in the bit strobe and injected commas of both polarities are compared on every clock against a reference model kept in the bench as a queue of received bits.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int WORD_W   = 10;
  localparam int MARK_LEN = 7;
  localparam int SYNC_N   = 2;
  // bit i = i-th bit in transmission order
  localparam logic [MARK_LEN-1:0] MARK_POS = 7'b1111100;
  localparam logic [MARK_LEN-1:0] MARK_NEG = ~MARK_POS;
endpackage

// File: rtl/rwf_en_sync.sv
module rwf_en_sync #(
  parameter int STAGES = rwf_pkg::SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  output logic en_out
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = en_in;
    end else begin : g_many
      always_comb stg_d = {stg_q[STAGES-2:0], en_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign en_out = stg_q[STAGES-1];

  // R8: the effective enable follows the input with a fixed lag
  a_r8_en_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_out) |-> $past(stg_q[0]));
endmodule

// File: rtl/rwf_window.sv
module rwf_window #(
  parameter int W = rwf_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_vld,
  input  logic         bit_in,
  output logic [W-1:0] win_nx,
  output logic         full_nx,
  output logic         full_q
);
  localparam int FW = $clog2(W + 1);

  logic [W-1:0]  win_q;
  logic [FW-1:0] fill_q;
  logic [FW-1:0] fill_nx;

  always_comb begin
    win_nx  = win_q;
    fill_nx = fill_q;
    if (bit_vld) begin
      // newest bit enters at the top, oldest sits in bit 0
      win_nx = {bit_in, win_q[W-1:1]};
      if (fill_q != FW'(W)) fill_nx = fill_q + 1'b1;
    end
    full_nx = (fill_nx == FW'(W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      win_q  <= win_nx;
      fill_q <= fill_nx;
    end
  end

  assign full_q = (fill_q == FW'(W));

  // R1: fill never exceeds the word width
  a_r1_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(W));
  // R3: without a strobe the window holds
  a_r3_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(win_q));
endmodule

// File: rtl/rwf_slicer.sv
module rwf_slicer #(
  parameter int W = rwf_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_vld,
  input  logic         en_eff,
  input  logic [W-1:0] win_nx,
  input  logic         full_nx,
  output logic         word_vld,
  output logic [W-1:0] word_out,
  output logic         comma_flag
);
  import rwf_pkg::*;
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q, cnt_nx, cnt_inc;
  logic [W-1:0]  word_q, word_nx;
  logic          vld_q, vld_nx;
  logic          flg_q, flg_nx;
  logic          hit, wrap, emit;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    hit     = bit_vld && full_nx && en_eff && (win_nx[MARK_LEN-1:0] == MARK_POS);
    wrap    = bit_vld && (cnt_inc == CW'(W));
    emit    = hit || wrap;
    cnt_nx  = cnt_q;
    if (bit_vld) cnt_nx = emit ? '0 : cnt_inc;
    word_nx = emit ? win_nx : word_q;
    vld_nx  = emit;
    flg_nx  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
      flg_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      word_q <= word_nx;
      vld_q  <= vld_nx;
      flg_q  <= flg_nx;
    end
  end

  assign word_vld   = vld_q;
  assign word_out   = word_q;
  assign comma_flag = flg_q;

  // R3: the bit count stays inside one character
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(W));
  // R7: a flag needs the synchronized enable on the accepting clock
  a_r7_flag_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    flg_q |-> $past(en_eff));
endmodule

// File: rtl/comma_word_framer.sv
module comma_word_framer #(
  parameter int W      = rwf_pkg::WORD_W,
  parameter int STAGES = rwf_pkg::SYNC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_en,
  input  logic         bit_vld,
  input  logic         bit_in,
  output logic         word_vld,
  output logic [W-1:0] word_out,
  output logic         comma_flag
);
  import rwf_pkg::*;

  logic [1:0]   rs_q;
  logic         rst_i_n;
  logic         en_eff;
  logic [W-1:0] win_nx;
  logic         full_nx;
  logic         full_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  rwf_en_sync #(.STAGES(STAGES)) i_sync (
    .clk(clk), .rst_n(rst_i_n), .en_in(frame_en), .en_out(en_eff)
  );

  rwf_window #(.W(W)) i_win (
    .clk(clk), .rst_n(rst_i_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .win_nx(win_nx), .full_nx(full_nx), .full_q(full_q)
  );

  rwf_slicer #(.W(W)) i_slc (
    .clk(clk), .rst_n(rst_i_n), .bit_vld(bit_vld), .en_eff(en_eff),
    .win_nx(win_nx), .full_nx(full_nx),
    .word_vld(word_vld), .word_out(word_out), .comma_flag(comma_flag)
  );

  // R1: no character before the window has filled
  a_r1_no_early_word: assert property (@(posedge clk) disable iff (!rst_i_n)
    word_vld |-> full_q);
  // R3: every strobe follows an accepted bit
  a_r3_vld_needs_bit: assert property (@(posedge clk) disable iff (!rst_i_n)
    word_vld |-> $past(bit_vld));
  // R4: a flagged character carries the positive comma
  a_r4_flag_pattern: assert property (@(posedge clk) disable iff (!rst_i_n)
    comma_flag |-> (word_vld && word_out[MARK_LEN-1:0] == MARK_POS));
  // R5: the negative form is never flagged
  a_r5_neg_ignored: assert property (@(posedge clk) disable iff (!rst_i_n)
    (word_vld && word_out[MARK_LEN-1:0] == MARK_NEG) |-> !comma_flag);
endmodule

// File: tb/test_comma_word_framer.sv
module test_comma_word_framer;
  localparam int CLK_P = 10;
  localparam logic [9:0] K_POS  = 10'b0101111100;
  localparam logic [9:0] K_NEG  = 10'b1010000011;
  localparam logic [9:0] FILL   = 10'b1010101010;

  logic clk = 1'b0;
  logic rst_n, frame_en, bit_vld, bit_in;
  logic word_vld, comma_flag;
  logic [9:0] word_out;

  always #(CLK_P/2) clk = ~clk;

  comma_word_framer i_comma_word_framer (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .bit_vld(bit_vld),
    .bit_in(bit_in), .word_vld(word_vld), .word_out(word_out),
    .comma_flag(comma_flag)
  );

  int checks = 0, errs = 0;
  int words_seen = 0, flags_seen = 0;
  logic [9:0] last_word;
  bit done = 0;

  // reference model
  bit hist[$];
  int since = 0;
  bit p1 = 0, p2 = 0;
  bit exp_vld = 0, exp_flg = 0;
  logic [9:0] exp_word = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete(); since = 0; p1 = 0; p2 = 0;
      exp_vld = 0; exp_flg = 0;
    end else begin
      bit en_now;
      en_now = p2;
      p2 = p1; p1 = frame_en;
      exp_vld = 0; exp_flg = 0;
      if (bit_vld) begin
        bit is_k;
        hist.push_back(bit_in);
        if (hist.size() > 10) void'(hist.pop_front());
        since++;
        is_k = (hist.size() == 10) && !hist[0] && !hist[1] &&
               hist[2] && hist[3] && hist[4] && hist[5] && hist[6];
        if ((en_now && is_k) || since == 10) begin
          exp_vld = 1; exp_flg = en_now && is_k; since = 0;
          for (int i = 0; i < 10; i++) exp_word[i] = hist[i];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(word_vld === exp_vld, "R3 strobe", {9'd0, word_vld}, {9'd0, exp_vld});
      chk(comma_flag === exp_flg, "R4 flag", {9'd0, comma_flag}, {9'd0, exp_flg});
      if (exp_vld) chk(word_out === exp_word, "R2 word", word_out, exp_word);
      if (word_vld) begin words_seen++; last_word = word_out; end
      if (comma_flag) flags_seen++;
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk); #1; bit_vld = 1; bit_in = b;
    @(negedge clk); #1; bit_vld = 0;
  endtask
  task automatic send_bits(input logic [9:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    $display("FAIL watchdog actual=%h expected=%h", 10'h0, 10'h1);
    finish_run();
  end

  initial begin
    int w0, f0;
    rst_n = 0; frame_en = 0; bit_vld = 0; bit_in = 0;
    repeat (4) @(negedge clk);
    chk(word_vld === 1'b0 && comma_flag === 1'b0, "R1 reset outputs",
        {8'd0, word_vld, comma_flag}, 10'd0);
    rst_n = 1;
    idle(6);

    // R1: nine bits give no word, the tenth gives one
    send_bits(FILL, 9); idle(1);
    chk(words_seen == 0, "R1 early word", 10'(words_seen), 10'd0);
    send_bits(FILL >> 9, 1); idle(1);
    chk(words_seen == 1, "R1 first word", 10'(words_seen), 10'd1);

    // R7: unframed, comma at offset 3 is not flagged
    send_bits(FILL, 3); send_bits(K_POS, 10); send_bits(FILL, 7);
    send_bits(K_POS, 10); idle(2);
    chk(flags_seen == 0, "R7 no flag unframed", 10'(flags_seen), 10'd0);
    chk(last_word == K_POS, "R7 boundary kept", last_word, K_POS);

    // R8 / R9: enable, then comma straddling the boundary
    frame_en = 1; idle(3);
    f0 = flags_seen;
    send_bits(FILL, 4); send_bits(K_POS, 10); idle(1);
    chk(flags_seen == f0 + 1, "R9 straddling comma", 10'(flags_seen), 10'(f0 + 1));
    chk(flags_seen == f0 + 1, "R8 enable effective", 10'(flags_seen), 10'(f0 + 1));

    // R6: next character exactly ten bits after the comma
    w0 = words_seen;
    send_bits(10'h155, 9); idle(1);
    chk(words_seen == w0, "R6 no partial", 10'(words_seen), 10'(w0));
    send_bits(10'h155 >> 9, 1); idle(1);
    chk(words_seen == w0 + 1, "R6 one word", 10'(words_seen), 10'(w0 + 1));
    chk(last_word == 10'h155, "R6 new boundary", last_word, 10'h155);

    // R5: negative commas at several offsets
    f0 = flags_seen;
    send_bits(K_NEG, 10); send_bits(FILL, 3); send_bits(K_NEG, 10);
    send_bits(FILL, 6); send_bits(K_NEG, 10); idle(2);
    chk(flags_seen == f0, "R5 negative ignored", 10'(flags_seen), 10'(f0));

    // R4: comma after arbitrary offset in framed mode
    f0 = flags_seen;
    send_bits(FILL, 7); send_bits(K_POS, 10); idle(1);
    chk(flags_seen == f0 + 1, "R4 comma found", 10'(flags_seen), 10'(f0 + 1));
    chk(last_word == K_POS, "R4 comma word", last_word, K_POS);

    // random framed stretch with gaps and commas
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) send_bits(K_POS, 10);
      else if (r == 1) send_bits(K_NEG, 10);
      else if (r == 2) idle(2);
      else send_bit($urandom_range(0, 1));
    end

    // R8: disable, then comma gives no flag
    send_bits(FILL, 10);
    frame_en = 0; idle(3);
    f0 = flags_seen;
    send_bits(FILL, 3); send_bits(K_POS, 10); send_bits(FILL, 10); idle(1);
    chk(flags_seen == f0, "R8 disable effective", 10'(flags_seen), 10'(f0));

    // random unframed stretch
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 9) == 0) send_bits(K_POS, 10);
      else send_bit($urandom_range(0, 1));
    end
    idle(3);
    finish_run();
  end
endmodule